// File: doc/BRIEF.md
# Packed Mixed-Sign Multiply-Add Unit

This block is a SIMD datapath that views two wide vector operands as arrays of bytes. Each byte of the first operand is read as an unsigned value and multiplied by the byte in the same position of the second operand, which is read as signed. The two products that fall in the same 16-bit word are summed. The sum is then clamped to the signed 16-bit range and written to that word lane.

A per-lane writemask chooses what each active lane receives. A lane whose mask bit is set gets the computed word. A lane whose mask bit is clear gets either the prior destination word (merging) or zero (zeroing). The active vector length is 128, 256 or 512 bits, and every lane above it is cleared. A separate legacy mode works on the low 128 bits only and passes the upper destination bits through unchanged.

The unit has one output register. A result appears one cycle after its valid strobe and stays in place until the next strobe.

Top module: `mixmac_unit`

## Requirements
- R1: Output word j is computed from bytes 2j and 2j+1 of both operands. Each `src1Vec` byte is taken as unsigned 0..255 and each `src2Vec` byte as two's complement -128..127. The two products are added.
- R2: A pair sum greater than 32767 produces 0x7FFF.
- R3: A pair sum less than -32768 produces 0x8000.
- R4: `validOut` is high in the cycle after a cycle with `validIn` high, and low otherwise. `resultVec` changes only in the cycle after `validIn` is high.
- R5: `lenSel` sets the number of active lanes: 0 gives 8 lanes (128 bits), 1 gives 16 lanes (256 bits), 2 or 3 gives 32 lanes (512 bits).
- R6: In non-legacy operation, every word lane at or above the active lane count is zero.
- R7: With `maskEnable` low, every active lane receives its computed word, whatever `laneMask` holds.
- R8: With `maskEnable` high, an active lane whose `laneMask` bit is 1 receives its computed word. If the bit is 0 and `zeroMode` is low, the lane receives the word of `oldDest` at the same position.
- R9: With `maskEnable` high and `zeroMode` high, an active lane whose `laneMask` bit is 0 receives zero.
- R10: With `legacyMode` high, lanes 0..7 receive their computed words regardless of `laneMask`, `maskEnable`, `zeroMode` and `lenSel`, and bits 511..128 equal `oldDest` bits 511..128.
- R11: After reset, `validOut` is 0 and `resultVec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| validIn | input | 1 | Operands valid; loads the output register |
| src1Vec | input | 512 | Unsigned byte operand |
| src2Vec | input | 512 | Signed byte operand |
| oldDest | input | 512 | Prior destination value, used for merging and legacy upper bits |
| laneMask | input | 32 | One mask bit per 16-bit lane |
| maskEnable | input | 1 | Apply laneMask when high |
| zeroMode | input | 1 | Masked-off lanes: 1 = zero, 0 = keep oldDest |
| lenSel | input | 2 | Active vector length select |
| legacyMode | input | 1 | 128-bit operation, upper bits preserved |
| validOut | output | 1 | Result valid |
| resultVec | output | 512 | Registered result vector |

## Verification
The hardest condition to reach is a pair sum that lands just past either clamp limit, because random bytes almost never push both products of a lane toward the same extreme. Directed vectors reach it directly: all-0xFF unsigned bytes against all-0x7F and against all-0x80 signed bytes give the extreme sums 64770 and -65280. Mask coverage uses alternating 0x5555/0xAAAA patterns at every length code, in both masking modes. Each check compares against a bench model built from the stated interpretation rules.

// File: rtl/mam_pkg.sv
`timescale 1ns/1ps
package mam_pkg;
  localparam int LANES      = 32;
  localparam int WORD_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int VEC_W      = LANES * WORD_W;
  localparam int LEGACY_LN  = LANES / 4;
  localparam int PROD_W     = 2 * BYTE_W + 1;
  localparam int SUM_W      = PROD_W + 1;

  typedef struct packed {
    logic             load;
    logic [LANES-1:0] takeRes;
    logic [LANES-1:0] takeOld;
  } ctrl_t;

  function automatic int laneCount(input logic [1:0] sel);
    case (sel)
      2'd0:    return LANES / 4;
      2'd1:    return LANES / 2;
      default: return LANES;
    endcase
  endfunction
endpackage

// File: rtl/mam_lane.sv
`timescale 1ns/1ps
module mam_lane
  import mam_pkg::*;
(
  input  logic [WORD_W-1:0] uPair,
  input  logic [WORD_W-1:0] sPair,
  output logic [WORD_W-1:0] satWord
);
  logic signed [PROD_W-1:0] prodLo;
  logic signed [PROD_W-1:0] prodHi;
  logic signed [SUM_W-1:0]  pairSum;

  localparam logic signed [SUM_W-1:0] MAX_POS = SUM_W'(32767);
  localparam logic signed [SUM_W-1:0] MIN_NEG = -SUM_W'(32768);

  always_comb begin
    prodLo  = $signed({1'b0, uPair[BYTE_W-1:0]}) * $signed(sPair[BYTE_W-1:0]);
    prodHi  = $signed({1'b0, uPair[WORD_W-1:BYTE_W]}) * $signed(sPair[WORD_W-1:BYTE_W]);
    pairSum = {prodLo[PROD_W-1], prodLo} + {prodHi[PROD_W-1], prodHi};
    if (pairSum > MAX_POS)
      satWord = 16'h7FFF;
    else if (pairSum < MIN_NEG)
      satWord = 16'h8000;
    else
      satWord = pairSum[WORD_W-1:0];
  end
endmodule

// File: rtl/mam_ctrl.sv
`timescale 1ns/1ps
module mam_ctrl
  import mam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             validIn,
  input  logic [LANES-1:0] laneMask,
  input  logic             maskEnable,
  input  logic             zeroMode,
  input  logic [1:0]       lenSel,
  input  logic             legacyMode,
  output ctrl_t            ctrl,
  output logic             validOut
);
  int activeLanes;

  always_comb begin
    activeLanes  = laneCount(lenSel);
    ctrl.load    = validIn;
    ctrl.takeRes = '0;
    ctrl.takeOld = '0;
    for (int j = 0; j < LANES; j++) begin
      if (legacyMode) begin
        ctrl.takeRes[j] = (j < LEGACY_LN);
        ctrl.takeOld[j] = (j >= LEGACY_LN);
      end else if (j < activeLanes) begin
        ctrl.takeRes[j] = !maskEnable || laneMask[j];
        ctrl.takeOld[j] = maskEnable && !laneMask[j] && !zeroMode;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validOut <= 1'b0;
    else        validOut <= validIn;
  end
endmodule

// File: rtl/mam_datapath.sv
`timescale 1ns/1ps
module mam_datapath
  import mam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [VEC_W-1:0] src1Vec,
  input  logic [VEC_W-1:0] src2Vec,
  input  logic [VEC_W-1:0] oldDest,
  output logic [VEC_W-1:0] resultVec
);
  logic [VEC_W-1:0] nextVec;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [WORD_W-1:0] satWord;
    mam_lane lane_i (
      .uPair  (src1Vec[j*WORD_W +: WORD_W]),
      .sPair  (src2Vec[j*WORD_W +: WORD_W]),
      .satWord(satWord)
    );
    always_comb begin
      if (ctrl.takeRes[j])
        nextVec[j*WORD_W +: WORD_W] = satWord;
      else if (ctrl.takeOld[j])
        nextVec[j*WORD_W +: WORD_W] = oldDest[j*WORD_W +: WORD_W];
      else
        nextVec[j*WORD_W +: WORD_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         resultVec <= '0;
    else if (ctrl.load) resultVec <= nextVec;
  end
endmodule

// File: rtl/mixmac_unit.sv
`timescale 1ns/1ps
module mixmac_unit
  import mam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             validIn,
  input  logic [VEC_W-1:0] src1Vec,
  input  logic [VEC_W-1:0] src2Vec,
  input  logic [VEC_W-1:0] oldDest,
  input  logic [LANES-1:0] laneMask,
  input  logic             maskEnable,
  input  logic             zeroMode,
  input  logic [1:0]       lenSel,
  input  logic             legacyMode,
  output logic             validOut,
  output logic [VEC_W-1:0] resultVec
);
  ctrl_t ctrl;

  mam_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .validIn   (validIn),
    .laneMask  (laneMask),
    .maskEnable(maskEnable),
    .zeroMode  (zeroMode),
    .lenSel    (lenSel),
    .legacyMode(legacyMode),
    .ctrl      (ctrl),
    .validOut  (validOut)
  );

  mam_datapath dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .src1Vec  (src1Vec),
    .src2Vec  (src2Vec),
    .oldDest  (oldDest),
    .resultVec(resultVec)
  );
endmodule

// File: rtl/mam_checker.sv
`timescale 1ns/1ps
module mam_checker
  import mam_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             validIn,
  input logic [VEC_W-1:0] oldDest,
  input logic [LANES-1:0] laneMask,
  input logic             maskEnable,
  input logic             zeroMode,
  input logic [1:0]       lenSel,
  input logic             legacyMode,
  input logic             validOut,
  input logic [VEC_W-1:0] resultVec
);
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    validIn |=> validOut);
  a_r4_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !validIn |=> !validOut);
  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !validIn |=> $stable(resultVec));
  a_r10_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (validIn && legacyMode) |=>
      resultVec[VEC_W-1:LEGACY_LN*WORD_W] == $past(oldDest[VEC_W-1:LEGACY_LN*WORD_W]));

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (validIn && !legacyMode && (j >= laneCount(lenSel))) |=>
        resultVec[j*WORD_W +: WORD_W] == '0);
    a_r8_merge_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (validIn && !legacyMode && maskEnable && !laneMask[j] && !zeroMode &&
       (j < laneCount(lenSel))) |=>
        resultVec[j*WORD_W +: WORD_W] == $past(oldDest[j*WORD_W +: WORD_W]));
    a_r9_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (validIn && !legacyMode && maskEnable && !laneMask[j] && zeroMode) |=>
        resultVec[j*WORD_W +: WORD_W] == '0);
  end
endmodule

bind mixmac_unit mam_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .validIn   (validIn),
  .oldDest   (oldDest),
  .laneMask  (laneMask),
  .maskEnable(maskEnable),
  .zeroMode  (zeroMode),
  .lenSel    (lenSel),
  .legacyMode(legacyMode),
  .validOut  (validOut),
  .resultVec (resultVec)
);

// File: tb/mixmac_unit_tb_top.sv
`timescale 1ns/1ps
module mixmac_unit_tb_top;
  localparam int NL = 32;
  localparam int VW = NL * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          validIn = 1'b0;
  logic [VW-1:0] src1Vec = '0;
  logic [VW-1:0] src2Vec = '0;
  logic [VW-1:0] oldDest = '0;
  logic [NL-1:0] laneMask = '0;
  logic          maskEnable = 1'b0;
  logic          zeroMode = 1'b0;
  logic [1:0]    lenSel = 2'd0;
  logic          legacyMode = 1'b0;
  logic          validOut;
  logic [VW-1:0] resultVec;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mixmac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .validIn(validIn),
    .src1Vec(src1Vec), .src2Vec(src2Vec), .oldDest(oldDest),
    .laneMask(laneMask), .maskEnable(maskEnable), .zeroMode(zeroMode),
    .lenSel(lenSel), .legacyMode(legacyMode),
    .validOut(validOut), .resultVec(resultVec)
  );

  function automatic logic [VW-1:0] rnd();
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] fill(input logic [7:0] b);
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 8; k++) v[k*8 +: 8] = b;
    return v;
  endfunction

  function automatic logic [15:0] pairRef(input logic [15:0] u, input logic [15:0] s);
    int total;
    total = 0;
    for (int h = 0; h < 2; h++) begin
      int uv, sv;
      uv = int'(u[h*8 +: 8]);
      sv = int'(s[h*8 +: 8]);
      if (sv >= 128) sv = sv - 256;
      total = total + uv * sv;
    end
    if (total > 32767) total = 32767;
    if (total < -32768) total = -32768;
    return total[15:0];
  endfunction

  function automatic logic [VW-1:0] model(
    input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] o,
    input logic [NL-1:0] m, input bit me, input bit zm, input logic [1:0] ls, input bit lg);
    logic [VW-1:0] v;
    int n;
    n = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    for (int j = 0; j < NL; j++) begin
      logic [15:0] calc;
      calc = pairRef(a[j*16 +: 16], b[j*16 +: 16]);
      if (lg)                 v[j*16 +: 16] = (j < 8) ? calc : o[j*16 +: 16];
      else if (j >= n)        v[j*16 +: 16] = 16'h0;
      else if (!me || m[j])   v[j*16 +: 16] = calc;
      else                    v[j*16 +: 16] = zm ? 16'h0 : o[j*16 +: 16];
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [VW-1:0] a, input logic [VW-1:0] b,
                     input logic [VW-1:0] o, input logic [NL-1:0] m, input bit me,
                     input bit zm, input logic [1:0] ls, input bit lg);
    @(negedge clk);
    src1Vec = a; src2Vec = b; oldDest = o; laneMask = m;
    maskEnable = me; zeroMode = zm; lenSel = ls; legacyMode = lg; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    check({req, " R4 valid"}, VW'(validOut), VW'(1));
    check(req, resultVec, model(a, b, o, m, me, zm, ls, lg));
  endtask

  task automatic test_reset();
    check("R11 validOut", VW'(validOut), VW'(0));
    check("R11 result", resultVec, '0);
  endtask

  task automatic test_products();
    logic [VW-1:0] a, b;
    a = '0; b = '0;
    a[15:0] = 16'h0203; b[15:0] = 16'h05FE;
    a[31:16] = 16'hFF00; b[31:16] = 16'h8000;
    run("R1 directed", a, b, '0, '0, 1'b0, 1'b0, 2'd2, 1'b0);
    check("R1 lane0", VW'(resultVec[15:0]), VW'(16'h0004));
    check("R1 lane1", VW'(resultVec[31:16]), VW'(16'h8080));
    for (int r = 0; r < 6; r++)
      run("R1 random", rnd(), rnd(), rnd(), '0, 1'b0, 1'b0, 2'd2, 1'b0);
  endtask

  task automatic test_saturate();
    run("R2 high clamp", fill(8'hFF), fill(8'h7F), '0, '0, 1'b0, 1'b0, 2'd2, 1'b0);
    check("R2 lane31", VW'(resultVec[VW-1 -: 16]), VW'(16'h7FFF));
    run("R3 low clamp", fill(8'hFF), fill(8'h80), '0, '0, 1'b0, 1'b0, 2'd2, 1'b0);
    check("R3 lane0", VW'(resultVec[15:0]), VW'(16'h8000));
  endtask

  task automatic test_lengths();
    for (int ls = 0; ls < 4; ls++)
      run("R5 R6 length", rnd(), rnd(), rnd(), '1, 1'b1, 1'b0, 2'(ls), 1'b0);
  endtask

  task automatic test_nomask();
    run("R7 mask ignored", rnd(), rnd(), rnd(), '0, 1'b0, 1'b1, 2'd2, 1'b0);
  endtask

  task automatic test_masks();
    for (int ls = 0; ls < 4; ls++) begin
      run("R8 merge 5555", rnd(), rnd(), rnd(), 32'h55555555, 1'b1, 1'b0, 2'(ls), 1'b0);
      run("R8 merge AAAA", rnd(), rnd(), rnd(), 32'hAAAAAAAA, 1'b1, 1'b0, 2'(ls), 1'b0);
      run("R9 zero 5555", rnd(), rnd(), rnd(), 32'h55555555, 1'b1, 1'b1, 2'(ls), 1'b0);
      run("R9 zero AAAA", rnd(), rnd(), rnd(), 32'hAAAAAAAA, 1'b1, 1'b1, 2'(ls), 1'b0);
    end
  endtask

  task automatic test_legacy();
    run("R10 legacy", rnd(), rnd(), rnd(), '0, 1'b1, 1'b1, 2'd0, 1'b1);
    run("R10 legacy len", rnd(), rnd(), rnd(), 32'h0F0F0F0F, 1'b1, 1'b0, 2'd2, 1'b1);
  endtask

  task automatic test_hold();
    logic [VW-1:0] held;
    run("R4 load", rnd(), rnd(), rnd(), '0, 1'b0, 1'b0, 2'd2, 1'b0);
    held = resultVec;
    @(negedge clk);
    src1Vec = rnd(); src2Vec = rnd(); oldDest = rnd(); lenSel = 2'd0;
    @(negedge clk);
    check("R4 idle valid", VW'(validOut), VW'(0));
    check("R4 hold result", resultVec, held);
  endtask

  initial begin
    #1;
    test_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_products();
    test_saturate();
    test_lengths();
    test_nomask();
    test_masks();
    test_legacy();
    test_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule